// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits behind the serial protocol engine of a byte-addressed non-volatile store. A transaction first latches a target address. The upper bits of that address choose a page and the low bits choose a starting offset inside it. Each data byte the engine receives is placed in a page-sized staging buffer at the current offset. A per-offset flag records which offsets were filled. The offset then advances and wraps inside the page, so a long burst overwrites its own earlier bytes.

When the engine reports a STOP and at least one byte was staged, the block writes every flagged byte of the page into the array in a single masked write. Bytes of the page that were not flagged keep their old values. It then holds a busy flag for a fixed number of clocks that stands for the programming time. The engine uses that flag to refuse new traffic. An abort from the engine, including the case where write protection rejected the transaction, throws the staged data away.

The array is a plain register memory that comes out of reset erased, with every byte equal to FFh. An asynchronous read port lets the surrounding logic, and the bench, see its contents.

Top module: `pgw_commit_top`

## Requirements
- R1: On `addr_load_i` the page number `addr_i[ADDR_W-1:5]` and the start offset `addr_i[4:0]` are latched, and the staging buffer is emptied. The default configuration has 64 pages of 32 bytes, so `ADDR_W` is 11; a 256-page array sets it to 13.
- R2: Each `byte_vld_i` stores `byte_i` at the current offset of the latched page. The offset then increments and wraps from 31 to 0; the page number never changes during a transaction.
- R3: A byte staged at an offset that already holds a staged byte replaces it, so the last value written to an offset is the one committed.
- R4: A STOP with at least one staged byte raises `commit_o` in that same cycle. All staged bytes appear on `rd_data_o` from the next cycle on.
- R5: A commit changes only the offsets that were staged; every other byte of the page keeps its previous value.
- R6: `busy_o` rises in the cycle after a commit and stays high for exactly `WRITE_TICKS` cycles.
- R7: After reset `busy_o` and `commit_o` are low and every array byte reads FFh.
- R8: A STOP with nothing staged gives no commit and leaves `busy_o` low.
- R9: `abort_i` empties the staging buffer, so a following STOP commits nothing and the array is unchanged.
- R10: While `busy_o` is high, all strobes are ignored. When busy falls the buffer is empty, so a STOP right after it commits nothing.
- R11: Strobes raised in the same cycle are resolved in this order of precedence: abort, then STOP, then address load, then data byte. An abort together with a STOP therefore discards the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_load_i | input | 1 | Latch `addr_i` as page and start offset |
| addr_i | input | ADDR_W | Start address of the transaction |
| byte_vld_i | input | 1 | A data byte is present on `byte_i` |
| byte_i | input | DATA_W | Data byte |
| stop_i | input | 1 | STOP seen on the bus |
| abort_i | input | 1 | Discard the transaction (abort or write-protect reject) |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | DATA_W | Array byte at `rd_addr_i` |
| busy_o | output | 1 | Write cycle in progress |
| commit_o | output | 1 | A commit is taken this cycle |

## Verification
The bound checker watches the following on every cycle:
- a commit is always followed by busy;
- no commit happens while busy;
- a STOP commits exactly when the checker's own port-level record says bytes were staged;
- every busy run lasts exactly the programmed length.

What the array holds can only be seen through the bench's scenarios, which read pages back after each transaction. These scenarios cover offset wrap, overwrite of a staged offset, preservation of untouched bytes in a partly written page, discard on abort, and traffic that is ignored while busy.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    // Resolved per-cycle action of the sequencer.
    typedef enum logic [2:0] {
        EV_NONE,
        EV_DROP,
        EV_STOP,
        EV_ADDR,
        EV_DATA
    } pgw_event_e;

    // Precedence: drop > stop > address load > data byte; nothing while busy.
    function automatic pgw_event_e pgw_pick(input logic busy,
                                            input logic drop,
                                            input logic stop,
                                            input logic addr,
                                            input logic data);
        pgw_event_e ev;
        if (busy)      ev = EV_NONE;
        else if (drop) ev = EV_DROP;
        else if (stop) ev = EV_STOP;
        else if (addr) ev = EV_ADDR;
        else if (data) ev = EV_DATA;
        else           ev = EV_NONE;
        return ev;
    endfunction

endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf
    import pgw_pkg::*;
#(
    parameter int PAGE_BYTES = 32,
    parameter int PAGE_W     = 6,
    parameter int DATA_W     = 8,
    parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  pgw_event_e                         ev_i,
    input  logic [PAGE_W-1:0]                  ld_page_i,
    input  logic [OFF_W-1:0]                   ld_off_i,
    input  logic [DATA_W-1:0]                  byte_i,
    input  logic                               clear_i,
    output logic [PAGE_W-1:0]                  page_o,
    output logic [PAGE_BYTES-1:0]              mask_o,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0]  data_o
);

    typedef struct packed {
        logic [PAGE_W-1:0]                 page;
        logic [OFF_W-1:0]                  off;
        logic [PAGE_BYTES-1:0]             mask;
        logic [PAGE_BYTES-1:0][DATA_W-1:0] data;
    } buf_state_t;

    buf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (ev_i)
            EV_DROP: begin
                st_d.mask = '0;
                st_d.data = '0;
            end
            EV_ADDR: begin
                st_d.page = ld_page_i;
                st_d.off  = ld_off_i;
                st_d.mask = '0;
                st_d.data = '0;
            end
            EV_DATA: begin
                st_d.data[st_q.off] = byte_i;
                st_d.mask[st_q.off] = 1'b1;
                // offset width equals log2 of page size: natural wrap
                st_d.off            = st_q.off + OFF_W'(1);
            end
            default: ;
        endcase
        if (clear_i) begin
            st_d.mask = '0;
            st_d.data = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign page_o = st_q.page;
    assign mask_o = st_q.mask;
    assign data_o = st_q.data;

endmodule

// File: rtl/pgw_cycle_timer.sv
module pgw_cycle_timer #(
    parameter int WRITE_TICKS = 200000,
    parameter int CNT_W       = $clog2(WRITE_TICKS + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        done_o = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                done_o    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end else if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(WRITE_TICKS - 1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign busy_o = st_q.busy;

endmodule

// File: rtl/pgw_array.sv
module pgw_array #(
    parameter int PAGE_BYTES = 32,
    parameter int PAGE_COUNT = 64,
    parameter int DATA_W     = 8,
    parameter int OFF_W      = $clog2(PAGE_BYTES),
    parameter int PAGE_W     = $clog2(PAGE_COUNT),
    parameter int ADDR_W     = PAGE_W + OFF_W
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic                               wr_en_i,
    input  logic [PAGE_W-1:0]                  wr_page_i,
    input  logic [PAGE_BYTES-1:0]              wr_mask_i,
    input  logic [PAGE_BYTES-1:0][DATA_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0]                  rd_addr_i,
    output logic [DATA_W-1:0]                  rd_data_o
);

    localparam int DEPTH = PAGE_BYTES * PAGE_COUNT;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (wr_en_i) begin
            for (int b = 0; b < PAGE_BYTES; b++) begin
                if (wr_mask_i[b]) mem_q[{wr_page_i, OFF_W'(b)}] <= wr_data_i[b];
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/pgw_commit_top.sv
module pgw_commit_top
    import pgw_pkg::*;
#(
    parameter int PAGE_BYTES  = 32,
    parameter int PAGE_COUNT  = 64,
    parameter int DATA_W      = 8,
    parameter int WRITE_TICKS = 200000,
    parameter int ADDR_W      = $clog2(PAGE_COUNT) + $clog2(PAGE_BYTES)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              stop_i,
    input  logic              abort_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o,
    output logic              commit_o
);

    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = $clog2(PAGE_COUNT);

    pgw_event_e                        ev;
    logic                              done;
    logic [PAGE_W-1:0]                 buf_page;
    logic [PAGE_BYTES-1:0]             buf_mask;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_data;

    assign ev       = pgw_pick(busy_o, abort_i, stop_i, addr_load_i, byte_vld_i);
    assign commit_o = (ev == EV_STOP) && (|buf_mask);

    pgw_page_buf #(
        .PAGE_BYTES (PAGE_BYTES),
        .PAGE_W     (PAGE_W),
        .DATA_W     (DATA_W)
    ) u_buf (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ev_i      (ev),
        .ld_page_i (addr_i[ADDR_W-1:OFF_W]),
        .ld_off_i  (addr_i[OFF_W-1:0]),
        .byte_i    (byte_i),
        .clear_i   (done),
        .page_o    (buf_page),
        .mask_o    (buf_mask),
        .data_o    (buf_data)
    );

    pgw_cycle_timer #(
        .WRITE_TICKS (WRITE_TICKS)
    ) u_tmr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (commit_o),
        .busy_o  (busy_o),
        .done_o  (done)
    );

    pgw_array #(
        .PAGE_BYTES (PAGE_BYTES),
        .PAGE_COUNT (PAGE_COUNT),
        .DATA_W     (DATA_W)
    ) u_arr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (commit_o),
        .wr_page_i (buf_page),
        .wr_mask_i (buf_mask),
        .wr_data_i (buf_data),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: rtl/pgw_commit_chk.sv
module pgw_commit_chk #(
    parameter int WRITE_TICKS = 200000,
    parameter int CNT_W       = $clog2(WRITE_TICKS + 1)
) (
    input logic clk_i,
    input logic rst_ni,
    input logic addr_load_i,
    input logic byte_vld_i,
    input logic stop_i,
    input logic abort_i,
    input logic busy_o,
    input logic commit_o
);

    // Port-level record of whether the open transaction has staged a byte.
    logic             staged_q;
    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            staged_q <= 1'b0;
        end else if (!busy_o) begin
            if (abort_i || stop_i || addr_load_i) staged_q <= 1'b0;
            else if (byte_vld_i)                  staged_q <= 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     run_q <= '0;
        else if (busy_o) run_q <= run_q + CNT_W'(1);
        else             run_q <= '0;
    end

    p_busy_after_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_o |=> busy_o);

    p_no_commit_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> !commit_o);

    p_commit_when_staged_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_i && !abort_i && !busy_o && staged_q) |-> commit_o);

    p_no_empty_commit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_o |-> (staged_q && stop_i && !abort_i));

    p_busy_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && run_q != '0) |-> (run_q == CNT_W'(WRITE_TICKS)));

    p_busy_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (run_q < CNT_W'(WRITE_TICKS)));

endmodule

bind pgw_commit_top pgw_commit_chk #(
    .WRITE_TICKS (WRITE_TICKS)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_load_i (addr_load_i),
    .byte_vld_i  (byte_vld_i),
    .stop_i      (stop_i),
    .abort_i     (abort_i),
    .busy_o      (busy_o),
    .commit_o    (commit_o)
);

// File: tb/pgw_commit_top_test.sv
module pgw_commit_top_test;

    localparam int PB     = 32;
    localparam int PC     = 64;
    localparam int TICKS  = 12;
    localparam int AW     = 11;
    localparam int DEPTH  = PB * PC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_load = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          bvld = 1'b0;
    logic [7:0]    bdat = '0;
    logic          stop = 1'b0;
    logic          abort = 1'b0;
    logic [AW-1:0] raddr = '0;
    logic [7:0]    rdata;
    logic          busy;
    logic          commit;

    int errors = 0;
    int checks = 0;
    logic [7:0] model [DEPTH];

    always #10 clk = ~clk;

    pgw_commit_top #(
        .PAGE_BYTES (PB),
        .PAGE_COUNT (PC),
        .DATA_W     (8),
        .WRITE_TICKS(TICKS)
    ) uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .addr_load_i (addr_load),
        .addr_i      (addr),
        .byte_vld_i  (bvld),
        .byte_i      (bdat),
        .stop_i      (stop),
        .abort_i     (abort),
        .rd_addr_i   (raddr),
        .rd_data_o   (rdata),
        .busy_o      (busy),
        .commit_o    (commit)
    );

    // vector: {start address, byte count, data seed}
    localparam int NV = 7;
    localparam logic [31:0] VEC [NV] = '{
        {16'h0000, 8'd1,  8'h11},
        {16'h0025, 8'd5,  8'h20},
        {16'h003E, 8'd4,  8'h40},
        {16'h0100, 8'd32, 8'h80},
        {16'h0104, 8'd2,  8'h05},
        {16'h01F0, 8'd40, 8'hA0},
        {16'h07FF, 8'd2,  8'h66}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [AW-1:0] a);
        @(negedge clk); addr_load = 1'b1; addr = a;
        @(negedge clk); addr_load = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] d);
        @(negedge clk); bvld = 1'b1; bdat = d;
        @(negedge clk); bvld = 1'b0;
    endtask

    task automatic do_stop(input logic with_abort, output logic seen);
        @(negedge clk); stop = 1'b1; abort = with_abort;
        #1 seen = commit;
        @(negedge clk); stop = 1'b0; abort = 1'b0;
    endtask

    task automatic do_abort();
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
    endtask

    // count busy cycles starting at the negedge after the commit edge
    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < 10 * TICKS) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_page(input int page, input string req);
        for (int b = 0; b < PB; b++) begin
            raddr = AW'(page * PB + b);
            #1 chk(req, int'(rdata), int'(model[page * PB + b]));
        end
    endtask

    initial begin
        #(100000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic seen;
        int   n;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: reset state
        chk("R7 busy", int'(busy), 0);
        chk("R7 commit", int'(commit), 0);
        raddr = 11'h000; #1 chk("R7 erased", int'(rdata), 8'hFF);
        raddr = 11'h555; #1 chk("R7 erased", int'(rdata), 8'hFF);
        raddr = 11'h7FF; #1 chk("R7 erased", int'(rdata), 8'hFF);

        // table walk: R1 R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            logic [AW-1:0] a;
            int cnt;
            logic [7:0] sd;
            a   = AW'(VEC[v][31:16]);
            cnt = int'(VEC[v][15:8]);
            sd  = VEC[v][7:0];
            do_load(a);
            for (int i = 0; i < cnt; i++) begin
                logic [7:0] d;
                d = sd + 8'(i * 3);
                do_byte(d);
                model[{a[AW-1:5], 5'(int'(a[4:0]) + i)}] = d;
            end
            do_stop(1'b0, seen);
            chk("R4 commit", int'(seen), 1);
            busy_len(n);
            chk("R6 busy length", n, TICKS);
            check_page(int'(a[AW-1:5]), "R2 R3 R5 page");
        end

        // R8: STOP with nothing staged
        do_load(11'h040);
        do_stop(1'b0, seen);
        chk("R8 commit", int'(seen), 0);
        chk("R8 busy", int'(busy), 0);

        // R9: abort discards staged bytes
        do_load(11'h060);
        do_byte(8'h01); do_byte(8'h02); do_byte(8'h03);
        do_abort();
        do_stop(1'b0, seen);
        chk("R9 commit", int'(seen), 0);
        chk("R9 busy", int'(busy), 0);
        check_page(3, "R9 page");

        // R11: abort with STOP in one cycle discards
        do_load(11'h0C0);
        do_byte(8'h5A);
        do_stop(1'b1, seen);
        chk("R11 commit", int'(seen), 0);
        do_stop(1'b0, seen);
        chk("R11 later stop", int'(seen), 0);
        check_page(6, "R11 page");

        // R10: strobes ignored while busy, buffer empty after
        do_load(11'h080);
        do_byte(8'hC1); do_byte(8'hC2);
        model[11'h080] = 8'hC1; model[11'h081] = 8'hC2;
        do_stop(1'b0, seen);
        chk("R4 commit", int'(seen), 1);
        chk("R10 busy", int'(busy), 1);
        do_load(11'h0A0);
        do_byte(8'h77);
        do_stop(1'b0, seen);
        chk("R10 commit while busy", int'(seen), 0);
        busy_len(n);
        do_stop(1'b0, seen);
        chk("R10 stop after cycle", int'(seen), 0);
        chk("R10 busy after", int'(busy), 0);
        check_page(4, "R10 page4");
        check_page(5, "R10 page5");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule